// File: doc/BRIEF.md
# Privilege Return and Environment-Call Unit

This block holds the current hart privilege level and the interrupt-enable part of the machine status word. It executes the SYSTEM-opcode instructions that leave a trap handler (uret, sret, mret) and the environment call (ecall). A decode stage presents a valid strobe and the 12-bit funct12 field. The exception return addresses for each privilege level arrive as inputs from the CSR file.

A legal return pops a small per-level stack held in the status word. The live enable takes the saved enable, the saved enable is forced to one, and for supervisor and machine returns the privilege is restored from the saved previous-privilege field, which is then cleared to user. The next PC is the matching exception PC. A return issued from too low a privilege raises an illegal-instruction pulse and changes nothing. An ecall raises an exception pulse with a cause code chosen by the current privilege. All results are registered and appear one clock after the instruction is sampled.

Top module: `trap_return_unit`

## Requirements
- R1: After synchronous reset the privilege output is machine (2'b11), the status output is all zero (saved machine privilege = user), next_pc_o is zero and every pulse output is low.
- R2: A valid instruction with funct12 0x002 (uret) is legal at every privilege: status bit 0 takes the old bit 4, bit 4 becomes 1, the privilege is unchanged, next_pc_o takes uepc_i and ret_taken_o pulses.
- R3: funct12 0x102 (sret) at user privilege (2'b00) pulses illegal_o and leaves privilege, status and next_pc_o unchanged.
- R4: A legal sret sets the privilege to the zero-extended bit 8 of status, copies bit 5 into bit 1, sets bit 5, clears bit 8, loads next_pc_o from sepc_i and pulses ret_taken_o.
- R5: funct12 0x302 (mret) at any privilege other than machine pulses illegal_o and leaves privilege, status and next_pc_o unchanged.
- R6: A legal mret sets the privilege to status bits 12:11, copies bit 7 into bit 3, sets bit 7, clears bits 12:11, loads next_pc_o from mepc_i and pulses ret_taken_o.
- R7: funct12 0x000 (ecall) pulses ecall_o with ecause_o equal to 8 at user, 9 at supervisor (2'b01) and 11 at machine; privilege, status and next_pc_o do not change.
- R8: funct12 0x001 (ebreak), any other funct12 value, and any cycle with instr_valid_i low produce no pulse and no change of privilege, status or next_pc_o.
- R9: Each result is visible in the cycle after the clock edge that samples the instruction, pulses last one cycle, and at most one of ret_taken_o, illegal_o and ecall_o is high.
- R10: Status bits 2, 6, 9 and 10 always read zero; only bits 0, 1, 3, 4, 5, 7, 8, 11 and 12 carry state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Decoded SYSTEM instruction (funct3 zero) is present |
| funct12_i | input | 12 | funct12 field of that instruction |
| uepc_i | input | XLEN | User exception PC |
| sepc_i | input | XLEN | Supervisor exception PC |
| mepc_i | input | XLEN | Machine exception PC |
| ret_taken_o | output | 1 | One-cycle pulse: a return was executed |
| next_pc_o | output | XLEN | Target of the last executed return |
| illegal_o | output | 1 | One-cycle pulse: return attempted from too low a privilege |
| ecall_o | output | 1 | One-cycle pulse: environment call |
| ecause_o | output | 4 | Cause code of the last environment call |
| status_o | output | 13 | Interrupt-enable portion of the status word |
| priv_o | output | 2 | Current privilege level |

## Verification
Every output is a register, so each result is due exactly one clock after the edge that samples the strobe. The bench drives at the falling edge, lets one rising edge pass, and compares all outputs at the next falling edge against a model it updates at the same point. A following cycle with the strobe low confirms the pulses have dropped and the state is held. The sweep runs every three-instruction sequence over seven funct12 codes from reset, which covers all privilege and status states reachable without trap entry.

// File: rtl/trp_pkg.sv
package trp_pkg;

  localparam int F12_W   = 12;
  localparam int ST_W    = 13;
  localparam int CAUSE_W = 4;
  localparam int PRIV_W  = 2;
  localparam int NUM_LVL = 3;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'b11;

  localparam int LVL_U = 0;
  localparam int LVL_S = 1;
  localparam int LVL_M = 2;

  localparam logic [F12_W-1:0] F12_ECALL  = 12'h000;
  localparam logic [F12_W-1:0] F12_EBREAK = 12'h001;
  localparam logic [F12_W-1:0] F12_URET   = 12'h002;
  localparam logic [F12_W-1:0] F12_SRET   = 12'h102;
  localparam logic [F12_W-1:0] F12_MRET   = 12'h302;

  // Status word bit positions
  localparam int ST_UIE    = 0;
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_UPIE   = 4;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;
  localparam int ST_MPP_HI = 12;

  localparam logic [ST_W-1:0] ST_LIVE_MASK = 13'h19BB;

  localparam logic [CAUSE_W-1:0] CAUSE_ECALL_U = 4'd8;
  localparam logic [CAUSE_W-1:0] CAUSE_ECALL_S = 4'd9;
  localparam logic [CAUSE_W-1:0] CAUSE_ECALL_M = 4'd11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ECALL,
    OP_URET,
    OP_SRET,
    OP_MRET
  } sys_op_e;

  function automatic int ie_pos(input int lvl);
    case (lvl)
      LVL_U:   return ST_UIE;
      LVL_S:   return ST_SIE;
      default: return ST_MIE;
    endcase
  endfunction

  function automatic int pie_pos(input int lvl);
    case (lvl)
      LVL_U:   return ST_UPIE;
      LVL_S:   return ST_SPIE;
      default: return ST_MPIE;
    endcase
  endfunction

  function automatic logic [PRIV_W-1:0] min_priv(input int lvl);
    case (lvl)
      LVL_U:   return PRIV_U;
      LVL_S:   return PRIV_S;
      default: return PRIV_M;
    endcase
  endfunction

endpackage

// File: rtl/trp_decode.sv
module trp_decode
  import trp_pkg::*;
(
  input  logic             valid_i,
  input  logic [F12_W-1:0] funct12_i,
  output sys_op_e          op_o
);

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      case (funct12_i)
        F12_ECALL:  op_o = OP_ECALL;
        F12_URET:   op_o = OP_URET;
        F12_SRET:   op_o = OP_SRET;
        F12_MRET:   op_o = OP_MRET;
        // ebreak belongs to the debug/trap path; it and unknown codes are no-ops here
        F12_EBREAK: op_o = OP_NONE;
        default:    op_o = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/trp_exec.sv
module trp_exec
  import trp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  sys_op_e             op_i,
  input  logic [PRIV_W-1:0]   priv_i,
  input  logic [ST_W-1:0]     status_i,
  input  logic [XLEN-1:0]     uepc_i,
  input  logic [XLEN-1:0]     sepc_i,
  input  logic [XLEN-1:0]     mepc_i,
  output logic                commit_o,
  output logic [PRIV_W-1:0]   priv_o,
  output logic [ST_W-1:0]     status_o,
  output logic                ret_o,
  output logic                illegal_o,
  output logic                ecall_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [XLEN-1:0]     pc_o
);

  localparam int LVL_IDX_W = $clog2(NUM_LVL);

  logic [NUM_LVL-1:0][ST_W-1:0]   popped;
  logic [NUM_LVL-1:0][PRIV_W-1:0] restored;
  logic [NUM_LVL-1:0]             allowed;
  logic [NUM_LVL-1:0][XLEN-1:0]   epc;
  logic [LVL_IDX_W-1:0]           lvl_sel;
  logic                           is_ret;

  assign epc[LVL_U] = uepc_i;
  assign epc[LVL_S] = sepc_i;
  assign epc[LVL_M] = mepc_i;

  // One status-stack pop per privilege level
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam int IE  = ie_pos(l);
    localparam int PIE = pie_pos(l);
    logic [ST_W-1:0]   pop_w;
    logic [PRIV_W-1:0] rest_w;

    always_comb begin
      pop_w      = status_i;
      pop_w[IE]  = status_i[PIE];
      pop_w[PIE] = 1'b1;
      if (l == LVL_S) begin
        pop_w[ST_SPP] = 1'b0;
      end else if (l == LVL_M) begin
        pop_w[ST_MPP_HI:ST_MPP_LO] = PRIV_U;
      end
    end

    if (l == LVL_U) begin : g_keep
      assign rest_w = priv_i;
    end else if (l == LVL_S) begin : g_spp
      assign rest_w = {1'b0, status_i[ST_SPP]};
    end else begin : g_mpp
      assign rest_w = status_i[ST_MPP_HI:ST_MPP_LO];
    end

    assign popped[l]   = pop_w;
    assign restored[l] = rest_w;
    assign allowed[l]  = (priv_i >= min_priv(l));
  end

  always_comb begin
    is_ret  = 1'b1;
    lvl_sel = LVL_IDX_W'(LVL_U);
    case (op_i)
      OP_URET: lvl_sel = LVL_IDX_W'(LVL_U);
      OP_SRET: lvl_sel = LVL_IDX_W'(LVL_S);
      OP_MRET: lvl_sel = LVL_IDX_W'(LVL_M);
      default: is_ret  = 1'b0;
    endcase
  end

  always_comb begin
    commit_o  = 1'b0;
    priv_o    = priv_i;
    status_o  = status_i;
    ret_o     = 1'b0;
    illegal_o = 1'b0;
    ecall_o   = 1'b0;
    cause_o   = CAUSE_ECALL_M;
    pc_o      = epc[lvl_sel];

    case (priv_i)
      PRIV_U:  cause_o = CAUSE_ECALL_U;
      PRIV_S:  cause_o = CAUSE_ECALL_S;
      default: cause_o = CAUSE_ECALL_M;
    endcase

    if (op_i == OP_ECALL) begin
      ecall_o = 1'b1;
    end else if (is_ret) begin
      if (allowed[lvl_sel]) begin
        commit_o = 1'b1;
        ret_o    = 1'b1;
        priv_o   = restored[lvl_sel];
        status_o = popped[lvl_sel];
      end else begin
        illegal_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid_i,
  input  logic [F12_W-1:0]   funct12_i,
  input  logic [XLEN-1:0]    uepc_i,
  input  logic [XLEN-1:0]    sepc_i,
  input  logic [XLEN-1:0]    mepc_i,
  output logic               ret_taken_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               illegal_o,
  output logic               ecall_o,
  output logic [CAUSE_W-1:0] ecause_o,
  output logic [ST_W-1:0]    status_o,
  output logic [PRIV_W-1:0]  priv_o
);

  sys_op_e              op_w;
  logic                 commit_w;
  logic [PRIV_W-1:0]    priv_nx;
  logic [ST_W-1:0]      status_nx;
  logic                 ret_w;
  logic                 illegal_w;
  logic                 ecall_w;
  logic [CAUSE_W-1:0]   cause_w;
  logic [XLEN-1:0]      pc_w;

  logic [PRIV_W-1:0]    priv_q;
  logic [ST_W-1:0]      status_q;
  logic                 ret_q;
  logic                 illegal_q;
  logic                 ecall_q;
  logic [CAUSE_W-1:0]   cause_q;
  logic [XLEN-1:0]      pc_q;

  trp_decode u_decode (
    .valid_i   (instr_valid_i),
    .funct12_i (funct12_i),
    .op_o      (op_w)
  );

  trp_exec #(
    .XLEN (XLEN)
  ) u_exec (
    .op_i      (op_w),
    .priv_i    (priv_q),
    .status_i  (status_q),
    .uepc_i    (uepc_i),
    .sepc_i    (sepc_i),
    .mepc_i    (mepc_i),
    .commit_o  (commit_w),
    .priv_o    (priv_nx),
    .status_o  (status_nx),
    .ret_o     (ret_w),
    .illegal_o (illegal_w),
    .ecall_o   (ecall_w),
    .cause_o   (cause_w),
    .pc_o      (pc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q    <= PRIV_M;
      status_q  <= '0;
      ret_q     <= 1'b0;
      illegal_q <= 1'b0;
      ecall_q   <= 1'b0;
      cause_q   <= '0;
      pc_q      <= '0;
    end else begin
      ret_q     <= ret_w;
      illegal_q <= illegal_w;
      ecall_q   <= ecall_w;
      if (commit_w) begin
        priv_q   <= priv_nx;
        status_q <= status_nx & ST_LIVE_MASK;
      end
      if (ret_w) begin
        pc_q <= pc_w;
      end
      if (ecall_w) begin
        cause_q <= cause_w;
      end
    end
  end

  assign ret_taken_o = ret_q;
  assign illegal_o   = illegal_q;
  assign ecall_o     = ecall_q;
  assign ecause_o    = cause_q;
  assign next_pc_o   = pc_q;
  assign status_o    = status_q;
  assign priv_o      = priv_q;

  // R9: result pulses are mutually exclusive
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_taken_o, illegal_o, ecall_o}));

  // R9: no pulse without an instruction on the previous edge
  p_pulse_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(instr_valid_i) |-> !(ret_taken_o || illegal_o || ecall_o));

  // R2: user return pops the user enable stack and keeps privilege
  p_uret_pop_r2: assert property (@(posedge clk) disable iff (rst)
    $past(op_w == OP_URET) |->
      ret_taken_o && status_q[ST_UPIE] &&
      (status_q[ST_UIE] == $past(status_q[ST_UPIE])) && (priv_q == $past(priv_q)));

  // R3: supervisor return from user faults without state change
  p_sret_user_ill_r3: assert property (@(posedge clk) disable iff (rst)
    $past(op_w == OP_SRET && priv_q == PRIV_U) |->
      illegal_o && $stable(status_q) && $stable(priv_q) && $stable(next_pc_o));

  // R4: legal supervisor return clears the saved privilege
  p_sret_pop_r4: assert property (@(posedge clk) disable iff (rst)
    $past(op_w == OP_SRET && priv_q != PRIV_U) |->
      ret_taken_o && !status_q[ST_SPP] && status_q[ST_SPIE] &&
      (priv_q == {1'b0, $past(status_q[ST_SPP])}));

  // R5: machine return below machine faults without state change
  p_mret_low_ill_r5: assert property (@(posedge clk) disable iff (rst)
    $past(op_w == OP_MRET && priv_q != PRIV_M) |->
      illegal_o && $stable(status_q) && $stable(priv_q) && $stable(next_pc_o));

  // R6: legal machine return restores the saved privilege
  p_mret_pop_r6: assert property (@(posedge clk) disable iff (rst)
    $past(op_w == OP_MRET && priv_q == PRIV_M) |->
      ret_taken_o && status_q[ST_MPIE] && (status_q[ST_MPP_HI:ST_MPP_LO] == PRIV_U) &&
      (priv_q == $past(status_q[ST_MPP_HI:ST_MPP_LO])));

  // R7: environment-call cause follows the unchanged privilege
  p_ecall_cause_r7: assert property (@(posedge clk) disable iff (rst)
    ecall_o |->
      ((priv_q == PRIV_U) ? (ecause_o == CAUSE_ECALL_U) :
       (priv_q == PRIV_S) ? (ecause_o == CAUSE_ECALL_S) : (ecause_o == CAUSE_ECALL_M)));

endmodule

// File: tb/trap_return_unit_tb.sv
`timescale 1ns/1ps
module trap_return_unit_tb;

  localparam int XLEN = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             instr_valid_i = 1'b0;
  logic [11:0]      funct12_i = '0;
  logic [XLEN-1:0]  uepc_i = '0;
  logic [XLEN-1:0]  sepc_i = '0;
  logic [XLEN-1:0]  mepc_i = '0;
  logic             ret_taken_o;
  logic [XLEN-1:0]  next_pc_o;
  logic             illegal_o;
  logic             ecall_o;
  logic [3:0]       ecause_o;
  logic [12:0]      status_o;
  logic [1:0]       priv_o;

  trap_return_unit #(.XLEN(XLEN)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .funct12_i     (funct12_i),
    .uepc_i        (uepc_i),
    .sepc_i        (sepc_i),
    .mepc_i        (mepc_i),
    .ret_taken_o   (ret_taken_o),
    .next_pc_o     (next_pc_o),
    .illegal_o     (illegal_o),
    .ecall_o       (ecall_o),
    .ecause_o      (ecause_o),
    .status_o      (status_o),
    .priv_o        (priv_o)
  );

  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int seq_id = 0;
  bit done = 1'b0;

  logic [1:0]      m_priv;
  logic [12:0]     m_st;
  logic [XLEN-1:0] m_pc;
  logic [3:0]      m_cause;

  function automatic logic [11:0] code_of(input int i);
    case (i)
      0: return 12'h000;
      1: return 12'h001;
      2: return 12'h002;
      3: return 12'h102;
      4: return 12'h302;
      5: return 12'h202;
      default: return 12'h105;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (seq %0d)", tag, what, act, exp, seq_id);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    instr_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_priv = 2'b11; m_st = '0; m_pc = '0; m_cause = '0;
    chk("R1", "priv", XLEN'(priv_o), XLEN'(2'b11));
    chk("R1", "status", XLEN'(status_o), '0);
    chk("R1", "next_pc", next_pc_o, '0);
    chk("R1", "pulses", XLEN'({ret_taken_o, illegal_o, ecall_o}), '0);
  endtask

  // Called at a falling edge; checks outputs one clock later
  task automatic step(input logic v, input logic [11:0] f);
    logic [1:0]  e_priv;
    logic [12:0] e_st;
    logic        e_ret, e_ill, e_ec;
    string       tag;
    e_priv = m_priv; e_st = m_st;
    e_ret = 1'b0; e_ill = 1'b0; e_ec = 1'b0;
    tag = "R8";
    uepc_i = 32'h0001_0000 + 32'(n_vec) * 16;
    sepc_i = 32'h0002_0004 + 32'(n_vec) * 16;
    mepc_i = 32'h0003_0008 + 32'(n_vec) * 16;
    if (v) begin
      case (f)
        12'h000: begin
          tag = "R7"; e_ec = 1'b1;
          m_cause = (m_priv == 2'b00) ? 4'd8 : (m_priv == 2'b01) ? 4'd9 : 4'd11;
        end
        12'h002: begin
          tag = "R2"; e_ret = 1'b1;
          e_st[0] = m_st[4]; e_st[4] = 1'b1; m_pc = uepc_i;
        end
        12'h102: begin
          if (m_priv == 2'b00) begin
            tag = "R3"; e_ill = 1'b1;
          end else begin
            tag = "R4"; e_ret = 1'b1;
            e_priv = {1'b0, m_st[8]};
            e_st[1] = m_st[5]; e_st[5] = 1'b1; e_st[8] = 1'b0; m_pc = sepc_i;
          end
        end
        12'h302: begin
          if (m_priv != 2'b11) begin
            tag = "R5"; e_ill = 1'b1;
          end else begin
            tag = "R6"; e_ret = 1'b1;
            e_priv = m_st[12:11];
            e_st[3] = m_st[7]; e_st[7] = 1'b1; e_st[12:11] = 2'b00; m_pc = mepc_i;
          end
        end
        default: tag = "R8";
      endcase
    end
    instr_valid_i = v;
    funct12_i = f;
    @(posedge clk);
    @(negedge clk);
    instr_valid_i = 1'b0;
    m_priv = e_priv; m_st = e_st;
    chk({tag, "/R9"}, "ret_taken", XLEN'(ret_taken_o), XLEN'(e_ret));
    chk({tag, "/R9"}, "illegal", XLEN'(illegal_o), XLEN'(e_ill));
    chk({tag, "/R9"}, "ecall", XLEN'(ecall_o), XLEN'(e_ec));
    if (e_ec) chk("R7", "ecause", XLEN'(ecause_o), XLEN'(m_cause));
    chk(tag, "priv", XLEN'(priv_o), XLEN'(m_priv));
    chk(tag, "status", XLEN'(status_o), XLEN'(m_st));
    chk(tag, "next_pc", next_pc_o, m_pc);
    chk("R10", "unused status bits", XLEN'(status_o & ~13'h19BB), '0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Directed: R1 idle, R7 ecall at machine, R2 uret twice
    step(1'b0, 12'h000);
    step(1'b1, 12'h000);
    step(1'b1, 12'h002);
    step(1'b1, 12'h002);
    step(1'b1, 12'h302);   // R6 to user
    step(1'b1, 12'h000);   // R7 at user
    step(1'b1, 12'h102);   // R3
    step(1'b1, 12'h302);   // R5
    // Exhaustive sweep of three-instruction sequences from reset
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        for (int c = 0; c < 7; c++) begin
          seq_id++;
          do_reset();
          step(1'b1, code_of(a));
          step(1'b0, code_of(c));   // R8: strobe low
          step(1'b1, code_of(b));
          step(1'b0, code_of(a));
          step(1'b1, code_of(c));
          step(1'b0, 12'h302);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule